// File: doc/BRIEF.md
# Blocking Direct-Mapped Write-Back Data Cache

This block sits between a processor and main memory and serves one word-sized access at a time. The processor side takes 4-byte requests and returns 4-byte responses. The memory side issues 16-byte line requests and takes 16-byte line responses. Every port uses a valid/ready handshake, and a transfer happens on a rising edge where both valid and ready are high. The default storage is 256 bytes held as 16 sets of one 16-byte line each. Writes use a write-back, write-allocate policy.

The block handles three request kinds. A read or a write that hits completes without memory traffic. On a miss, a dirty victim is first written back as a full line. The missing line is then fetched, and the original access completes against it. A third kind, write-init, installs a tag and one word directly with no memory traffic, which lets software preload the cache. A control FSM drives a datapath that holds the tag and data arrays. The valid and dirty bits live in the control unit. A parameter selects the index bits for the single-bank case or for a four-bank slice. In the four-bank case the two bank-select address bits are kept inside the stored tag, so victim addresses can still be rebuilt.

Top module: `dmc_cache`

## Requirements
- R1: After reset the block accepts a request (`cpu_req_rdy`=1), presents no response, issues no memory request and is not ready for a memory response. Every line starts invalid, so the first access to any set misses.
- R2: A processor request is 77 bits: kind [76:74], opaque [73:66], address [65:34], length [33:32], data [31:0]. A processor response is 47 bits: kind [46:44], opaque [43:36], hit flag [35:34], length [33:32], data [31:0]. Kind codes are 0 for read, 1 for write and 2 for write-init. A response echoes the request's kind and opaque, and its length is 0.
- R3: A write-init response becomes valid in the third cycle after the cycle in which the request was accepted. Its hit flag, length and data are all zero, and no memory request is made during the transaction.
- R4: A write-init marks the addressed line valid and clean, with the request's tag and the request's word in place. A later read of that word hits and returns the data without memory traffic.
- R5: A read hit responds in the third cycle after acceptance, with hit flag 1 and the stored word in the data field.
- R6: A write hit responds with hit flag 1 and data 0, updates the word and marks the line dirty.
- R7: A miss to an invalid or clean line issues exactly one memory request. That request is a read (kind 0) of the line-aligned address. The response carries hit flag 0 and, for a read, the refilled word.
- R8: A miss to a valid dirty line first issues a memory write (kind 1) of the whole victim line to the victim's line-aligned address, and then issues the refill read.
- R9: A write miss refills the line and then merges the written word into it. The other words keep their memory values.
- R10: In the single-bank map the word offset is address[3:2], the set index is address[7:4] and the tag is address[31:8]. A different tag on the same index misses.
- R11: From acceptance until the response handshake, no further request is accepted. While `cpu_rsp_rdy` is low, the response stays valid and unchanged.
- R12: A memory request stays valid and unchanged until accepted. The memory side is quiet (no request, no response-ready) whenever the block is idle. A memory request is a 175-bit message with kind [174:172], opaque [171:164], address [163:132], length [131:128] and line [127:0]. A memory response is 145 bits with its line in [127:0], word 0 in the low 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_msg | input | 77 | Processor request message |
| cpu_req_val | input | 1 | Processor request valid |
| cpu_req_rdy | output | 1 | Cache can accept a request |
| cpu_rsp_msg | output | 47 | Processor response message |
| cpu_rsp_val | output | 1 | Processor response valid |
| cpu_rsp_rdy | input | 1 | Processor takes the response |
| mem_req_msg | output | 175 | Line request to memory |
| mem_req_val | output | 1 | Memory request valid |
| mem_req_rdy | input | 1 | Memory accepts the request |
| mem_rsp_msg | input | 145 | Line response from memory |
| mem_rsp_val | input | 1 | Memory response valid |
| mem_rsp_rdy | output | 1 | Cache takes the memory response |

## Verification
A wrong valid bit or tag shows up on the very next access to that set. A stale hit returns data with hit flag 1 and no memory request, while a false miss makes an unexpected line read appear on the memory port. A lost dirty bit hides until the line is evicted and re-read, when the written word comes back with its old memory value. The bench therefore forces that eviction and refetches the line. Control-state faults show up within a few cycles as a wrong response latency, a request accepted while busy, or a memory message that changes before its handshake.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
   localparam int WORD_W   = 32;
   localparam int LINE_W   = 128;
   localparam int WORDS    = LINE_W / WORD_W;
   localparam int OFF_W    = 4;
   localparam int ADDR_W   = 32;

   localparam logic [2:0] K_READ  = 3'd0;
   localparam logic [2:0] K_WRITE = 3'd1;
   localparam logic [2:0] K_INIT  = 3'd2;

   typedef struct packed {
      logic [2:0]        kind;
      logic [7:0]        opq;
      logic [ADDR_W-1:0] addr;
      logic [1:0]        len;
      logic [WORD_W-1:0] data;
   } cpu_req_t;

   typedef struct packed {
      logic [2:0]        kind;
      logic [7:0]        opq;
      logic [1:0]        test;
      logic [1:0]        len;
      logic [WORD_W-1:0] data;
   } cpu_rsp_t;

   typedef struct packed {
      logic [2:0]        kind;
      logic [7:0]        opq;
      logic [ADDR_W-1:0] addr;
      logic [3:0]        len;
      logic [LINE_W-1:0] data;
   } mem_req_t;

   typedef struct packed {
      logic [2:0]        kind;
      logic [7:0]        opq;
      logic [1:0]        test;
      logic [3:0]        len;
      logic [LINE_W-1:0] data;
   } mem_rsp_t;

   typedef enum logic [3:0] {
      S_IDLE, S_TCHK, S_INIT, S_RDHIT, S_WRHIT,
      S_EVREQ, S_EVWAIT, S_FILREQ, S_FILWAIT, S_RESP
   } st_e;
endpackage

// File: rtl/dmc_addr_map.sv
module dmc_addr_map
   import dmc_pkg::*;
#(
   parameter int IDX_W = 4,
   parameter int TAG_W = 24,
   parameter int BANKS = 1
)(
   input  logic [ADDR_W-1:0] addr,
   input  logic [TAG_W-1:0]  vic_tag,
   output logic [IDX_W-1:0]  idx,
   output logic [TAG_W-1:0]  tag,
   output logic [1:0]        wofs,
   output logic [ADDR_W-1:0] req_line,
   output logic [ADDR_W-1:0] vic_line
);
   assign wofs = addr[3:2];

   generate
      if (BANKS == 1) begin : g_one
         assign idx      = addr[OFF_W +: IDX_W];
         assign tag      = addr[ADDR_W-1:OFF_W+IDX_W];
         assign req_line = {tag, idx, {OFF_W{1'b0}}};
         assign vic_line = {vic_tag, idx, {OFF_W{1'b0}}};
      end else begin : g_four
         assign idx      = addr[OFF_W+2 +: IDX_W];
         assign tag      = {addr[ADDR_W-1:OFF_W+2+IDX_W], addr[OFF_W+1:OFF_W]};
         assign req_line = {tag[TAG_W-1:2], idx, tag[1:0], {OFF_W{1'b0}}};
         assign vic_line = {vic_tag[TAG_W-1:2], idx, vic_tag[1:0], {OFF_W{1'b0}}};
      end
   endgenerate
endmodule

// File: rtl/dmc_dpath.sv
module dmc_dpath
   import dmc_pkg::*;
#(
   parameter int NUM_SETS = 16,
   parameter int BANKS    = 1,
   localparam int IDX_W   = $clog2(NUM_SETS),
   localparam int TAG_W   = ADDR_W - OFF_W - IDX_W
)(
   input  logic              clk,
   input  logic              rst,
   input  logic [76:0]       cpu_req_msg,
   input  logic [LINE_W-1:0] fill_data,
   input  logic              req_load,
   input  logic              tag_wen,
   input  logic              word_wen,
   input  logic              line_wen,
   input  logic              evict_sel,
   input  logic              hit_q,
   output logic [2:0]        req_kind,
   output logic [IDX_W-1:0]  req_idx,
   output logic              tag_match,
   output logic [46:0]       cpu_rsp_msg,
   output logic [174:0]      mem_req_msg
);
   cpu_req_t                 req_q;
   logic [TAG_W-1:0]         tag_arr  [NUM_SETS];
   logic [WORD_W-1:0]        data_arr [NUM_SETS][WORDS];
   logic [TAG_W-1:0]         req_tag;
   logic [1:0]               wofs;
   logic [ADDR_W-1:0]        req_line, vic_line;
   logic [LINE_W-1:0]        cur_line;
   cpu_rsp_t                 rsp;
   mem_req_t                 mreq;

   dmc_addr_map #(.IDX_W(IDX_W), .TAG_W(TAG_W), .BANKS(BANKS)) u_map (
      .addr    (req_q.addr),
      .vic_tag (tag_arr[req_idx]),
      .idx     (req_idx),
      .tag     (req_tag),
      .wofs    (wofs),
      .req_line(req_line),
      .vic_line(vic_line)
   );

   always_ff @(posedge clk) begin
      if (rst)           req_q <= '0;
      else if (req_load) req_q <= cpu_req_t'(cpu_req_msg);
   end

   always_ff @(posedge clk) begin
      if (tag_wen)  tag_arr[req_idx] <= req_tag;
      if (word_wen) data_arr[req_idx][wofs] <= req_q.data;
      if (line_wen)
         for (int w = 0; w < WORDS; w++)
            data_arr[req_idx][w] <= fill_data[WORD_W*w +: WORD_W];
   end

   generate
      for (genvar w = 0; w < WORDS; w++) begin : g_line
         assign cur_line[WORD_W*w +: WORD_W] = data_arr[req_idx][w];
      end
   endgenerate

   assign req_kind  = req_q.kind;
   assign tag_match = (tag_arr[req_idx] == req_tag);

   always_comb begin
      rsp.kind = req_q.kind;
      rsp.opq  = req_q.opq;
      rsp.test = {1'b0, hit_q};
      rsp.len  = 2'd0;
      rsp.data = (req_q.kind == K_READ) ? data_arr[req_idx][wofs] : '0;
      mreq.kind = evict_sel ? K_WRITE : K_READ;
      mreq.opq  = 8'd0;
      mreq.addr = evict_sel ? vic_line : req_line;
      mreq.len  = 4'd0;
      mreq.data = evict_sel ? cur_line : '0;
   end

   assign cpu_rsp_msg = rsp;
   assign mem_req_msg = mreq;
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
   import dmc_pkg::*;
#(
   parameter int NUM_SETS = 16,
   localparam int IDX_W   = $clog2(NUM_SETS)
)(
   input  logic             clk,
   input  logic             rst,
   input  logic             cpu_req_val,
   output logic             cpu_req_rdy,
   output logic             cpu_rsp_val,
   input  logic             cpu_rsp_rdy,
   output logic             mem_req_val,
   input  logic             mem_req_rdy,
   input  logic             mem_rsp_val,
   output logic             mem_rsp_rdy,
   input  logic [2:0]       req_kind,
   input  logic [IDX_W-1:0] req_idx,
   input  logic             tag_match,
   output logic             req_load,
   output logic             tag_wen,
   output logic             word_wen,
   output logic             line_wen,
   output logic             evict_sel,
   output logic             hit_q
);
   st_e                 st, nxt;
   logic [NUM_SETS-1:0] valid_q, dirty_q;
   logic                v_we, v_in, d_we, d_in, hit_ld, hit;

   assign hit = valid_q[req_idx] && tag_match;

   always_comb begin
      nxt = st;
      cpu_req_rdy = 1'b0; cpu_rsp_val = 1'b0;
      mem_req_val = 1'b0; mem_rsp_rdy = 1'b0;
      req_load = 1'b0; tag_wen = 1'b0; word_wen = 1'b0; line_wen = 1'b0;
      evict_sel = 1'b0; hit_ld = 1'b0;
      v_we = 1'b0; v_in = 1'b0; d_we = 1'b0; d_in = 1'b0;
      unique case (st)
         S_IDLE: begin
            cpu_req_rdy = 1'b1;
            if (cpu_req_val) begin req_load = 1'b1; nxt = S_TCHK; end
         end
         S_TCHK: begin
            hit_ld = 1'b1;
            if (req_kind == K_INIT)                        nxt = S_INIT;
            else if (hit)                                  nxt = (req_kind == K_WRITE) ? S_WRHIT : S_RDHIT;
            else if (valid_q[req_idx] && dirty_q[req_idx]) nxt = S_EVREQ;
            else                                           nxt = S_FILREQ;
         end
         S_INIT: begin
            tag_wen = 1'b1; word_wen = 1'b1;
            v_we = 1'b1; v_in = 1'b1; d_we = 1'b1; d_in = 1'b0;
            nxt = S_RESP;
         end
         S_RDHIT: nxt = S_RESP;
         S_WRHIT: begin
            word_wen = 1'b1; d_we = 1'b1; d_in = 1'b1;
            nxt = S_RESP;
         end
         S_EVREQ: begin
            mem_req_val = 1'b1; evict_sel = 1'b1;
            if (mem_req_rdy) nxt = S_EVWAIT;
         end
         S_EVWAIT: begin
            mem_rsp_rdy = 1'b1;
            if (mem_rsp_val) nxt = S_FILREQ;
         end
         S_FILREQ: begin
            mem_req_val = 1'b1;
            if (mem_req_rdy) nxt = S_FILWAIT;
         end
         S_FILWAIT: begin
            mem_rsp_rdy = 1'b1;
            if (mem_rsp_val) begin
               line_wen = 1'b1; tag_wen = 1'b1;
               v_we = 1'b1; v_in = 1'b1; d_we = 1'b1; d_in = 1'b0;
               nxt = (req_kind == K_WRITE) ? S_WRHIT : S_RDHIT;
            end
         end
         S_RESP: begin
            cpu_rsp_val = 1'b1;
            if (cpu_rsp_rdy) nxt = S_IDLE;
         end
         default: nxt = S_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st      <= S_IDLE;
         valid_q <= '0;
         dirty_q <= '0;
         hit_q   <= 1'b0;
      end else begin
         st <= nxt;
         if (v_we)   valid_q[req_idx] <= v_in;
         if (d_we)   dirty_q[req_idx] <= d_in;
         if (hit_ld) hit_q <= hit && (req_kind != K_INIT);
      end
   end
endmodule

// File: rtl/dmc_cache.sv
module dmc_cache
   import dmc_pkg::*;
#(
   parameter int NUM_SETS = 16,
   parameter int BANKS    = 1
)(
   input  logic         clk,
   input  logic         rst,
   input  logic [76:0]  cpu_req_msg,
   input  logic         cpu_req_val,
   output logic         cpu_req_rdy,
   output logic [46:0]  cpu_rsp_msg,
   output logic         cpu_rsp_val,
   input  logic         cpu_rsp_rdy,
   output logic [174:0] mem_req_msg,
   output logic         mem_req_val,
   input  logic         mem_req_rdy,
   input  logic [144:0] mem_rsp_msg,
   input  logic         mem_rsp_val,
   output logic         mem_rsp_rdy
);
   localparam int IDX_W = $clog2(NUM_SETS);

   generate
      if (BANKS != 1 && BANKS != 4) begin : g_bad_banks
         $error("dmc_cache: BANKS must be 1 or 4");
      end
      if ((1 << IDX_W) != NUM_SETS) begin : g_bad_sets
         $error("dmc_cache: NUM_SETS must be a power of two");
      end
   endgenerate

   logic [2:0]       req_kind;
   logic [IDX_W-1:0] req_idx;
   logic             tag_match, req_load, tag_wen, word_wen, line_wen, evict_sel, hit_q;
   mem_rsp_t         mrsp;

   assign mrsp = mem_rsp_t'(mem_rsp_msg);

   dmc_ctrl #(.NUM_SETS(NUM_SETS)) u_ctrl (
      .clk(clk), .rst(rst),
      .cpu_req_val(cpu_req_val), .cpu_req_rdy(cpu_req_rdy),
      .cpu_rsp_val(cpu_rsp_val), .cpu_rsp_rdy(cpu_rsp_rdy),
      .mem_req_val(mem_req_val), .mem_req_rdy(mem_req_rdy),
      .mem_rsp_val(mem_rsp_val), .mem_rsp_rdy(mem_rsp_rdy),
      .req_kind(req_kind), .req_idx(req_idx), .tag_match(tag_match),
      .req_load(req_load), .tag_wen(tag_wen), .word_wen(word_wen),
      .line_wen(line_wen), .evict_sel(evict_sel), .hit_q(hit_q)
   );

   dmc_dpath #(.NUM_SETS(NUM_SETS), .BANKS(BANKS)) u_dpath (
      .clk(clk), .rst(rst),
      .cpu_req_msg(cpu_req_msg), .fill_data(mrsp.data),
      .req_load(req_load), .tag_wen(tag_wen), .word_wen(word_wen),
      .line_wen(line_wen), .evict_sel(evict_sel), .hit_q(hit_q),
      .req_kind(req_kind), .req_idx(req_idx), .tag_match(tag_match),
      .cpu_rsp_msg(cpu_rsp_msg), .mem_req_msg(mem_req_msg)
   );
endmodule

// File: rtl/dmc_checker.sv
module dmc_checker (
   input logic         clk,
   input logic         rst,
   input logic [76:0]  cpu_req_msg,
   input logic         cpu_req_val,
   input logic         cpu_req_rdy,
   input logic [46:0]  cpu_rsp_msg,
   input logic         cpu_rsp_val,
   input logic         cpu_rsp_rdy,
   input logic [174:0] mem_req_msg,
   input logic         mem_req_val,
   input logic         mem_req_rdy,
   input logic         mem_rsp_rdy
);
   logic [7:0] opq_q;
   logic       init_busy;
   logic       acc;

   assign acc = cpu_req_val && cpu_req_rdy;

   always_ff @(posedge clk) begin
      if (rst) begin
         opq_q <= '0;
         init_busy <= 1'b0;
      end else begin
         if (acc) begin
            opq_q     <= cpu_req_msg[73:66];
            init_busy <= (cpu_req_msg[76:74] == 3'd2);
         end else if (cpu_rsp_val && cpu_rsp_rdy) begin
            init_busy <= 1'b0;
         end
      end
   end

   AST_BLOCKING: assert property (@(posedge clk) disable iff (rst)
      cpu_rsp_val |-> !cpu_req_rdy); // R11
   AST_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
      (cpu_rsp_val && !cpu_rsp_rdy) |=> (cpu_rsp_val && $stable(cpu_rsp_msg))); // R11
   AST_MEMREQ_HOLD: assert property (@(posedge clk) disable iff (rst)
      (mem_req_val && !mem_req_rdy) |=> (mem_req_val && $stable(mem_req_msg))); // R12
   AST_MEM_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
      cpu_req_rdy |-> (!mem_req_val && !mem_rsp_rdy)); // R12
   AST_INIT_LATENCY: assert property (@(posedge clk) disable iff (rst)
      (acc && cpu_req_msg[76:74] == 3'd2) |=> ##2 cpu_rsp_val); // R3
   AST_INIT_NO_MEM: assert property (@(posedge clk) disable iff (rst)
      init_busy |-> !mem_req_val); // R3
   AST_RSP_OPAQUE: assert property (@(posedge clk) disable iff (rst)
      cpu_rsp_val |-> (cpu_rsp_msg[43:36] == opq_q)); // R2
endmodule

bind dmc_cache dmc_checker u_chk (
   .clk(clk), .rst(rst),
   .cpu_req_msg(cpu_req_msg), .cpu_req_val(cpu_req_val), .cpu_req_rdy(cpu_req_rdy),
   .cpu_rsp_msg(cpu_rsp_msg), .cpu_rsp_val(cpu_rsp_val), .cpu_rsp_rdy(cpu_rsp_rdy),
   .mem_req_msg(mem_req_msg), .mem_req_val(mem_req_val), .mem_req_rdy(mem_req_rdy),
   .mem_rsp_rdy(mem_rsp_rdy)
);

// File: tb/sim_dmc_cache.sv
`timescale 1ns/1ps
module sim_dmc_cache;
   import dmc_pkg::*;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [76:0]  cpu_req_msg = '0;
   logic         cpu_req_val = 1'b0;
   logic         cpu_req_rdy;
   logic [46:0]  cpu_rsp_msg;
   logic         cpu_rsp_val;
   logic         cpu_rsp_rdy = 1'b1;
   logic [174:0] mem_req_msg;
   logic         mem_req_val;
   logic         mem_req_rdy = 1'b0;
   logic [144:0] mem_rsp_msg = '0;
   logic         mem_rsp_val = 1'b0;
   logic         mem_rsp_rdy;

   int n_chk = 0, n_fail = 0, cyc = 0;
   logic [31:0]  mem [0:4095];
   int           mlog_n = 0;
   logic [2:0]   mlog_k [0:7];
   logic [31:0]  mlog_a [0:7];
   logic [127:0] mlog_d [0:7];

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   dmc_cache u0 (.*);

   function automatic logic [31:0] memf(input logic [31:0] a);
      return 32'h5A5A0000 ^ a;
   endfunction

   task automatic chk(input bit ok, input string rq, input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual %0h expected %0h", rq, act, exp);
      end
   endtask

   // memory model: fixed one-cycle turnaround, request ready alternates
   initial begin
      for (int i = 0; i < 4096; i++) mem[i] = memf(32'(i * 4));
      forever begin
         bit rqf, rsf;
         mem_req_t r;
         logic [127:0] ln;
         @(negedge clk);
         rqf = mem_req_val && mem_req_rdy;
         rsf = mem_rsp_val && mem_rsp_rdy;
         r = mem_req_t'(mem_req_msg);
         ln = '0;
         if (rqf) begin
            if (mlog_n < 8) begin
               mlog_k[mlog_n] = r.kind; mlog_a[mlog_n] = r.addr; mlog_d[mlog_n] = r.data;
            end
            mlog_n++;
            for (int w = 0; w < 4; w++) begin
               if (r.kind == K_WRITE) mem[(r.addr[13:0] >> 2) + w] = r.data[32*w +: 32];
               ln[32*w +: 32] = mem[(r.addr[13:0] >> 2) + w];
            end
         end
         @(posedge clk); #1;
         if (rsf) mem_rsp_val = 1'b0;
         if (rqf) begin
            mem_rsp_msg = {r.kind, 8'h00, 2'b00, 4'h0, (r.kind == K_WRITE) ? 128'h0 : ln};
            mem_rsp_val = 1'b1;
         end
         mem_req_rdy = !rst && !mem_req_rdy;
      end
   end

   task automatic xact(input logic [2:0] k, input logic [7:0] o, input logic [31:0] a,
                       input logic [31:0] d, input int hold, output cpu_rsp_t r, output int lat);
      int c0;
      @(negedge clk);
      cpu_rsp_rdy = (hold == 0);
      cpu_req_msg = {k, o, a, 2'b00, d};
      cpu_req_val = 1'b1;
      while (!cpu_req_rdy) @(negedge clk);
      c0 = cyc;
      @(posedge clk); #1 cpu_req_val = 1'b0;
      @(negedge clk);
      while (!cpu_rsp_val) @(negedge clk);
      lat = cyc - c0;
      r = cpu_rsp_t'(cpu_rsp_msg);
      for (int i = 0; i < hold; i++) begin
         @(negedge clk);
         chk(cpu_rsp_val && !cpu_req_rdy && cpu_rsp_msg == r, "R11 response held under backpressure",
             {cpu_rsp_val, cpu_req_rdy, cpu_rsp_msg}, {1'b1, 1'b0, 47'(r)});
      end
      cpu_rsp_rdy = 1'b1;
      @(posedge clk); #1;
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk(cpu_req_rdy == 1'b1, "R1 ready after reset", cpu_req_rdy, 1);
      chk(cpu_rsp_val == 1'b0, "R1 no response after reset", cpu_rsp_val, 0);
      chk(mem_req_val == 1'b0, "R1 no memory request after reset", mem_req_val, 0);
      chk(mem_rsp_rdy == 1'b0, "R12 memory side quiet when idle", mem_rsp_rdy, 0);
   endtask

   task automatic t_init_then_read;
      cpu_rsp_t r; int lat, m0;
      m0 = mlog_n;
      xact(K_INIT, 8'h11, 32'h1000, 32'hDEADBEEF, 0, r, lat);
      chk(lat == 3, "R3 write-init latency", lat, 3);
      chk(r.kind == K_INIT && r.opq == 8'h11, "R2 write-init echo kind/opaque", {r.kind, r.opq}, {K_INIT, 8'h11});
      chk(r.test == 0 && r.len == 0 && r.data == 0, "R3 write-init fields zero", {r.test, r.len, r.data}, 0);
      chk(mlog_n == m0, "R3 write-init no memory traffic", mlog_n - m0, 0);
      xact(K_READ, 8'h12, 32'h1000, 32'h0, 0, r, lat);
      chk(lat == 3, "R5 read hit latency", lat, 3);
      chk(r.test == 1 && r.data == 32'hDEADBEEF, "R4 read after write-init hits", {r.test, r.data}, {2'd1, 32'hDEADBEEF});
      chk(mlog_n == m0, "R4 no memory traffic on hit", mlog_n - m0, 0);
   endtask

   task automatic t_fill_sets;
      cpu_rsp_t r; int lat, m0;
      for (int i = 0; i < 16; i++) xact(K_INIT, 8'(i), 32'h2000 + 32'(i * 16), 32'h10000000 + 32'(i), 0, r, lat);
      m0 = mlog_n;
      for (int i = 0; i < 16; i++) begin
         xact(K_READ, 8'(i + 32), 32'h2000 + 32'(i * 16), 32'h0, 0, r, lat);
         chk(r.test == 1 && r.data == 32'h10000000 + 32'(i) && r.opq == 8'(i + 32),
             "R10 each set index addr[7:4] holds its own line", {r.test, r.opq, r.data},
             {2'd1, 8'(i + 32), 32'h10000000 + 32'(i)});
      end
      chk(mlog_n == m0, "R4 sixteen hits without memory traffic", mlog_n - m0, 0);
   endtask

   task automatic t_read_miss_clean;
      cpu_rsp_t r; int lat;
      mlog_n = 0;
      xact(K_READ, 8'h40, 32'h0304, 32'h0, 0, r, lat);
      chk(mlog_n == 1, "R7 one request on clean miss", mlog_n, 1);
      chk(mlog_k[0] == K_READ && mlog_a[0] == 32'h0300, "R7 refill kind/address", {mlog_k[0], mlog_a[0]}, {K_READ, 32'h0300});
      chk(r.test == 0 && r.data == memf(32'h0304), "R7 miss response data", {r.test, r.data}, {2'd0, memf(32'h0304)});
   endtask

   task automatic t_write_hit;
      cpu_rsp_t r; int lat;
      mlog_n = 0;
      xact(K_WRITE, 8'h41, 32'h0308, 32'h12345678, 0, r, lat);
      chk(r.kind == K_WRITE && r.test == 1 && r.data == 0, "R6 write hit response", {r.kind, r.test, r.data}, {K_WRITE, 2'd1, 32'h0});
      xact(K_READ, 8'h42, 32'h0308, 32'h0, 0, r, lat);
      chk(r.test == 1 && r.data == 32'h12345678, "R6 written word read back", {r.test, r.data}, {2'd1, 32'h12345678});
      chk(mlog_n == 0, "R6 write hit stays in cache", mlog_n, 0);
   endtask

   task automatic t_dirty_evict;
      cpu_rsp_t r; int lat;
      logic [127:0] vic;
      vic = {memf(32'h030C), 32'h12345678, memf(32'h0304), memf(32'h0300)};
      mlog_n = 0;
      xact(K_READ, 8'h50, 32'h0704, 32'h0, 0, r, lat);
      chk(mlog_n == 2, "R8 two requests on dirty miss", mlog_n, 2);
      chk(mlog_k[0] == K_WRITE && mlog_a[0] == 32'h0300, "R8 writeback first", {mlog_k[0], mlog_a[0]}, {K_WRITE, 32'h0300});
      chk(mlog_d[0] == vic, "R8 victim line data", mlog_d[0], vic);
      chk(mlog_k[1] == K_READ && mlog_a[1] == 32'h0700, "R8 refill second", {mlog_k[1], mlog_a[1]}, {K_READ, 32'h0700});
      chk(r.test == 0 && r.data == memf(32'h0704), "R8 response after evict", {r.test, r.data}, {2'd0, memf(32'h0704)});
   endtask

   task automatic t_write_miss;
      cpu_rsp_t r; int lat;
      mlog_n = 0;
      xact(K_WRITE, 8'h60, 32'h0514, 32'hCAFEF00D, 0, r, lat);
      chk(mlog_n == 1 && mlog_k[0] == K_READ && mlog_a[0] == 32'h0510, "R9 write miss refills clean line",
          {mlog_n[7:0], mlog_k[0], mlog_a[0]}, {8'd1, K_READ, 32'h0510});
      chk(r.test == 0 && r.data == 0, "R9 write miss response", {r.test, r.data}, 0);
      xact(K_READ, 8'h61, 32'h0514, 32'h0, 0, r, lat);
      chk(r.test == 1 && r.data == 32'hCAFEF00D, "R9 merged word", {r.test, r.data}, {2'd1, 32'hCAFEF00D});
      xact(K_READ, 8'h62, 32'h0518, 32'h0, 0, r, lat);
      chk(r.test == 1 && r.data == memf(32'h0518), "R9 neighbour word from memory", {r.test, r.data}, {2'd1, memf(32'h0518)});
   endtask

   task automatic t_conflict;
      cpu_rsp_t r; int lat;
      xact(K_READ, 8'h70, 32'h0704, 32'h0, 0, r, lat);
      chk(r.test == 1, "R10 same tag hits", r.test, 1);
      mlog_n = 0;
      xact(K_READ, 8'h71, 32'h1704, 32'h0, 0, r, lat);
      chk(r.test == 0 && mlog_n == 1 && mlog_a[0] == 32'h1700, "R10 different tag same index misses",
          {r.test, mlog_n[7:0], mlog_a[0]}, {2'd0, 8'd1, 32'h1700});
      xact(K_READ, 8'h72, 32'h0308, 32'h0, 0, r, lat);
      chk(r.test == 0 && r.data == 32'h12345678, "R8 written-back word refetched", {r.test, r.data}, {2'd0, 32'h12345678});
   endtask

   task automatic t_backpressure;
      cpu_rsp_t r; int lat;
      xact(K_INIT, 8'h80, 32'h3020, 32'hA0A0A0A0, 4, r, lat);
      chk(lat == 3 && r.opq == 8'h80, "R11 write-init under backpressure", {lat[7:0], r.opq}, {8'd3, 8'h80});
      @(negedge clk);
      chk(cpu_req_rdy && !cpu_rsp_val && !mem_rsp_rdy, "R11 idle again after handshake",
          {cpu_req_rdy, cpu_rsp_val, mem_rsp_rdy}, 3'b100);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      t_reset();
      t_init_then_read();
      t_fill_sets();
      t_read_miss_clean();
      t_write_hit();
      t_dirty_evict();
      t_write_miss();
      t_conflict();
      t_backpressure();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule